// File: doc/BRIEF.md
# Back-EMF Zero-Crossing Event Generator

This block produces the zero-crossing event that times commutation in a sensorless brushless motor drive. Once per commutation step it waits for the commutation event and then the demagnetisation event. After that it watches for the rotor's back-EMF crossing. The crossing can be seen in two ways. A hardware crossing comes from the synchronised comparator, which is sampled only while PWM sits on the sensing group of outputs and is accepted after a run of agreeing samples. A simulated crossing comes from the free-running step timer reaching a stored value. When both sources are enabled, the first one to arrive wins. The step then gives one single-cycle event pulse and sets a latched interrupt flag.

One register serves two purposes: it holds the compare value, and it records the timer value of a hardware crossing. Firmware writes it to plan simulated crossings. The block checks it at the demagnetisation event. If the value is already behind the timer at that moment, the event fires at once and the register takes the current timer value.

The sequencer has four states. `ST_IDLE` waits for the first commutation event. `ST_WAIT_D` waits for demagnetisation. `ST_ARMED` is the detection window. `ST_DONE` has spent the step's event. The transitions are as follows. A commutation event (`c_evt`) moves any state to `ST_WAIT_D`. A demagnetisation event (`d_evt`) moves `ST_WAIT_D` to `ST_ARMED`, or directly to `ST_DONE` when the stale-compare check fires. An accepted crossing moves `ST_ARMED` to `ST_DONE`.

Top module: `bemf_zc_gen`

## Requirements
- R1: After reset, `zc_pulse`, `irq_flag`, `irq` and `zc_src_hw` are 0, `zreg_q` is 0 and the sequencer is in `ST_IDLE`.
- R2: No event is produced until a `c_evt` has been followed by a `d_evt`. Comparator activity and timer matches before that are ignored. If `c_evt` and `d_evt` are high in the same cycle, `c_evt` wins and the block waits for a later `d_evt`.
- R3: The comparator is sampled only in the armed state, with hardware mode enabled and `pwm_grp` equal to `cfg_sense_grp`. Any cycle outside that condition clears the run of agreeing samples.
- R4: A hardware crossing is accepted on the (`cfg_filt_len`+1)-th consecutive qualifying sample. A non-qualifying sample restarts the count from zero.
- R5: A sample qualifies when (`cmp_in` XOR `cfg_cmp_inv`) equals `cfg_edge_rise`. With `cfg_edge_rise`=1 the block looks for the level after a rising crossing, and with 0 for the level after a falling one.
- R6: On an accepted hardware crossing, `zreg_q` takes the `timer_val` of the accepting sample cycle, and `zc_src_hw` reads 1 with the pulse. With `cfg_hw_en`=0, no hardware crossing is detected.
- R7: With `cfg_sim_en`=1 in the armed state, `timer_val == zreg_q` fires an event with `zc_src_hw`=0. With `cfg_sim_en`=0, no simulated event fires.
- R8: At most one event is produced per step. If both sources are enabled, the first one wins. Later crossings or matches are ignored until the next `c_evt`.
- R9: With `cfg_sim_en`=1, in the cycle where `d_evt` is taken, if `zreg_q <= timer_val` the event fires at once (`zc_src_hw`=0) and `zreg_q` takes that `timer_val`. This includes the case where the two are equal.
- R10: Each event sets `irq_flag` in the same clock edge as `zc_pulse`. `irq` equals `irq_flag AND cfg_irq_mask`.
- R11: A one-cycle `irq_clr` clears `irq_flag`. An event in the same cycle wins, and the flag stays set.
- R12: `zreg_wr` loads `zreg_wdata` into `zreg_q` at the next edge. A hardware capture or stale-compare overwrite in the same cycle takes priority over the write.
- R13: `zc_pulse` is high for exactly one cycle, one clock edge after the cycle in which the crossing was decided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_in | input | 1 | Synchronised back-EMF comparator output |
| timer_val | input | TW | Free-running step timer |
| c_evt | input | 1 | Commutation event strobe |
| d_evt | input | 1 | Demagnetisation event strobe |
| pwm_grp | input | 1 | Output group currently carrying PWM |
| cfg_sense_grp | input | 1 | Group in which the comparator is sampled |
| cfg_edge_rise | input | 1 | 1: rising crossing, 0: falling crossing |
| cfg_cmp_inv | input | 1 | Invert comparator polarity |
| cfg_filt_len | input | FW | Agreeing samples needed, minus one |
| cfg_hw_en | input | 1 | Enable hardware crossing and capture |
| cfg_sim_en | input | 1 | Enable simulated crossing |
| cfg_irq_mask | input | 1 | Interrupt mask |
| zreg_wr | input | 1 | Software write strobe for the shared register |
| zreg_wdata | input | TW | Software write data |
| irq_clr | input | 1 | Write-one-to-clear strobe for the flag |
| zc_pulse | output | 1 | One-cycle zero-crossing event |
| zc_src_hw | output | 1 | Source of the last event (1 hardware) |
| irq_flag | output | 1 | Latched event flag |
| irq | output | 1 | Masked interrupt |
| zreg_q | output | TW | Shared capture/compare register |

## Verification
Several functions of this block can fall in the same cycle. The bench provokes each collision and judges the outcome at the ports. An event can be decided in the same cycle as `irq_clr`: the bench raises the clear on the exact cycle the stale-compare check fires and expects the flag to stay set. A hardware capture can coincide with a software write: the bench drives `zreg_wr` on the accepting sample and expects the register to hold the timer value rather than the written data. In the same way, a timer match after the step's event has been spent must leave the pulse low.

// File: rtl/bemf_zc_pkg.sv
package bemf_zc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT_D = 2'd1,
        ST_ARMED  = 2'd2,
        ST_DONE   = 2'd3
    } zc_state_e;

    typedef enum logic {
        SRC_SIM = 1'b0,
        SRC_HW  = 1'b1
    } zc_src_e;

endpackage

// File: rtl/bemf_zc_filter.sv
module bemf_zc_filter #(
    parameter int FW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_en,
    input  logic          cmp_in,
    input  logic          edge_rise,
    input  logic          cmp_inv,
    input  logic [FW-1:0] filt_len,
    output logic          hw_hit
);

    logic [FW-1:0] run_q;
    logic          qual;

    // sample agrees with the expected post-crossing level
    assign qual = ((cmp_in ^ cmp_inv) == edge_rise);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!sample_en || !qual) begin
            run_q <= '0;
        end else if (run_q != filt_len) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign hw_hit = sample_en && qual && (run_q == filt_len);

    // R3: leaving the sampling window empties the run
    p_run_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> (run_q == '0));

    // R4: a failed sample restarts the count
    p_run_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !qual) |=> (run_q == '0));

endmodule

// File: rtl/bemf_zc_seq.sv
module bemf_zc_seq
    import bemf_zc_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          c_evt,
    input  logic          d_evt,
    input  logic          grp_match,
    input  logic          hw_en,
    input  logic          sim_en,
    input  logic          hw_hit,
    input  logic [TW-1:0] timer,
    input  logic [TW-1:0] zreg,
    output logic          sample_en,
    output logic          fire,
    output logic          fire_hw,
    output logic          stale_ld
);

    zc_state_e state_q;
    zc_state_e state_d;

    logic armed;
    logic stale;
    logic sim_match;
    logic hw_take;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // decision outputs
    always_comb begin
        armed     = (state_q == ST_ARMED);
        sample_en = armed && hw_en && grp_match;
        stale     = (state_q == ST_WAIT_D) && d_evt && !c_evt && sim_en && (zreg <= timer);
        sim_match = armed && sim_en && (timer == zreg);
        hw_take   = armed && hw_hit;
        fire      = !c_evt && (stale || sim_match || hw_take);
        fire_hw   = !c_evt && hw_take;
        stale_ld  = stale;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (c_evt) begin
            state_d = ST_WAIT_D;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_WAIT_D: if (d_evt) state_d = stale ? ST_DONE : ST_ARMED;
                ST_ARMED:  if (fire) state_d = ST_DONE;
                ST_DONE:   state_d = ST_DONE;
            endcase
        end
    end

    // R2: detection window opens only on a demagnetisation event
    p_arm_on_d_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_ARMED) |-> $past(d_evt));

    // R8: an event spends the step
    p_event_spends_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (state_q == ST_DONE));

    // R8: no second event in a spent step
    p_single_per_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> !fire);

endmodule

// File: rtl/bemf_zc_store.sv
module bemf_zc_store
    import bemf_zc_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] timer,
    input  logic          fire,
    input  logic          fire_hw,
    input  logic          stale_ld,
    input  logic          sw_wr,
    input  logic [TW-1:0] sw_data,
    input  logic          irq_clr,
    output logic [TW-1:0] zreg,
    output logic          zc_pulse,
    output logic          zc_src_hw,
    output logic          irq_flag
);

    zc_src_e src_q;
    logic    cap;

    assign cap = fire_hw || stale_ld;

    // shared capture / compare register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zreg <= '0;
        end else if (cap) begin
            zreg <= timer;
        end else if (sw_wr) begin
            zreg <= sw_data;
        end
    end

    // event pulse, source and latched flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zc_pulse <= 1'b0;
            src_q    <= SRC_SIM;
            irq_flag <= 1'b0;
        end else begin
            zc_pulse <= fire;
            if (fire) begin
                src_q <= fire_hw ? SRC_HW : SRC_SIM;
            end
            if (fire) begin
                irq_flag <= 1'b1;
            end else if (irq_clr) begin
                irq_flag <= 1'b0;
            end
        end
    end

    assign zc_src_hw = (src_q == SRC_HW);

    // R13: pulse lasts one cycle
    p_pulse_one_cycle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        zc_pulse |=> !zc_pulse);

    // R10: every pulse comes with the flag
    p_flag_with_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        zc_pulse |-> irq_flag);

    // R11: clear without a competing event empties the flag
    p_clear_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !fire) |=> !irq_flag);

    // R12: hardware capture beats a software write
    p_capture_priority_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && cap && (sw_data != timer)) |=> (zreg != $past(sw_data)));

endmodule

// File: rtl/bemf_zc_gen.sv
module bemf_zc_gen #(
    parameter int TW = 16,
    parameter int FW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_in,
    input  logic [TW-1:0] timer_val,
    input  logic          c_evt,
    input  logic          d_evt,
    input  logic          pwm_grp,
    input  logic          cfg_sense_grp,
    input  logic          cfg_edge_rise,
    input  logic          cfg_cmp_inv,
    input  logic [FW-1:0] cfg_filt_len,
    input  logic          cfg_hw_en,
    input  logic          cfg_sim_en,
    input  logic          cfg_irq_mask,
    input  logic          zreg_wr,
    input  logic [TW-1:0] zreg_wdata,
    input  logic          irq_clr,
    output logic          zc_pulse,
    output logic          zc_src_hw,
    output logic          irq_flag,
    output logic          irq,
    output logic [TW-1:0] zreg_q
);

    logic sample_en;
    logic hw_hit;
    logic fire;
    logic fire_hw;
    logic stale_ld;
    logic grp_match;

    assign grp_match = (pwm_grp == cfg_sense_grp);

    bemf_zc_filter #(.FW(FW)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .cmp_in    (cmp_in),
        .edge_rise (cfg_edge_rise),
        .cmp_inv   (cfg_cmp_inv),
        .filt_len  (cfg_filt_len),
        .hw_hit    (hw_hit)
    );

    bemf_zc_seq #(.TW(TW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .c_evt     (c_evt),
        .d_evt     (d_evt),
        .grp_match (grp_match),
        .hw_en     (cfg_hw_en),
        .sim_en    (cfg_sim_en),
        .hw_hit    (hw_hit),
        .timer     (timer_val),
        .zreg      (zreg_q),
        .sample_en (sample_en),
        .fire      (fire),
        .fire_hw   (fire_hw),
        .stale_ld  (stale_ld)
    );

    bemf_zc_store #(.TW(TW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .timer     (timer_val),
        .fire      (fire),
        .fire_hw   (fire_hw),
        .stale_ld  (stale_ld),
        .sw_wr     (zreg_wr),
        .sw_data   (zreg_wdata),
        .irq_clr   (irq_clr),
        .zreg      (zreg_q),
        .zc_pulse  (zc_pulse),
        .zc_src_hw (zc_src_hw),
        .irq_flag  (irq_flag)
    );

    assign irq = irq_flag && cfg_irq_mask;

    // R9: a stale compare value is replaced by the timer at once
    p_stale_overwrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stale_ld |=> (zc_pulse && !zc_src_hw && (zreg_q == $past(timer_val))));

endmodule

// File: tb/bemf_zc_gen_bench.sv
module bemf_zc_gen_bench;

    localparam int TW = 16;
    localparam int FW = 3;
    localparam int NV = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmp_in = 1'b0;
    logic [TW-1:0] timer_val = '0;
    logic          c_evt = 1'b0;
    logic          d_evt = 1'b0;
    logic          pwm_grp = 1'b0;
    logic          cfg_sense_grp = 1'b1;
    logic          cfg_edge_rise = 1'b1;
    logic          cfg_cmp_inv = 1'b0;
    logic [FW-1:0] cfg_filt_len = 3'd1;
    logic          cfg_hw_en = 1'b1;
    logic          cfg_sim_en = 1'b1;
    logic          cfg_irq_mask = 1'b1;
    logic          zreg_wr = 1'b0;
    logic [TW-1:0] zreg_wdata = '0;
    logic          irq_clr = 1'b0;
    logic          zc_pulse;
    logic          zc_src_hw;
    logic          irq_flag;
    logic          irq;
    logic [TW-1:0] zreg_q;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    bemf_zc_gen #(.TW(TW), .FW(FW)) u_bemf_zc_gen (
        .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .timer_val(timer_val),
        .c_evt(c_evt), .d_evt(d_evt), .pwm_grp(pwm_grp),
        .cfg_sense_grp(cfg_sense_grp), .cfg_edge_rise(cfg_edge_rise),
        .cfg_cmp_inv(cfg_cmp_inv), .cfg_filt_len(cfg_filt_len),
        .cfg_hw_en(cfg_hw_en), .cfg_sim_en(cfg_sim_en), .cfg_irq_mask(cfg_irq_mask),
        .zreg_wr(zreg_wr), .zreg_wdata(zreg_wdata), .irq_clr(irq_clr),
        .zc_pulse(zc_pulse), .zc_src_hw(zc_src_hw), .irq_flag(irq_flag),
        .irq(irq), .zreg_q(zreg_q)
    );

    // {c, d, grp, cmp, timer, exp_pulse, exp_src_hw, exp_flag, exp_zreg}
    // config: sense group 1, rising, no inversion, filt_len 1 (two samples), both sources on
    localparam logic [38:0] VEC [NV] = '{
        {4'b0011, 16'h000A, 3'b000, 16'h0100}, // 0  R2 idle, comparator ignored
        {4'b1011, 16'h000B, 3'b000, 16'h0100}, // 1  R2 c taken
        {4'b0011, 16'h000C, 3'b000, 16'h0100}, // 2  R2 no d yet
        {4'b0111, 16'h000D, 3'b000, 16'h0100}, // 3  d taken, compare not stale
        {4'b0011, 16'h000E, 3'b000, 16'h0100}, // 4  R4 one sample
        {4'b0001, 16'h000F, 3'b000, 16'h0100}, // 5  R3 PWM leaves sense group
        {4'b0011, 16'h0010, 3'b000, 16'h0100}, // 6  R4 one sample
        {4'b0010, 16'h0011, 3'b000, 16'h0100}, // 7  R4 failed sample
        {4'b0011, 16'h0012, 3'b000, 16'h0100}, // 8  R4 one sample
        {4'b0011, 16'h0013, 3'b111, 16'h0013}, // 9  R6 accepted, captured
        {4'b0011, 16'h0014, 3'b011, 16'h0013}, // 10 R8 spent step
        {4'b0010, 16'h0013, 3'b011, 16'h0013}, // 11 R8 match ignored
        {4'b1010, 16'h0005, 3'b011, 16'h0013}, // 12 new step
        {4'b0110, 16'h0006, 3'b011, 16'h0013}, // 13 d, compare ahead
        {4'b0010, 16'h0012, 3'b011, 16'h0013}, // 14
        {4'b0010, 16'h0013, 3'b101, 16'h0013}, // 15 R7 simulated match
        {4'b0010, 16'h0014, 3'b001, 16'h0013}  // 16 R13 pulse gone
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic c, input logic d, input logic g, input logic cm,
                         input logic [TW-1:0] t);
        c_evt = c; d_evt = d; pwm_grp = g; cmp_in = cm; timer_val = t;
    endtask

    task automatic wr_zreg(input logic [TW-1:0] v);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
        zreg_wr = 1'b1; zreg_wdata = v;
        tick();
        zreg_wr = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pulse", {31'd0, zc_pulse}, 32'd0);
        chk("R1 flag", {31'd0, irq_flag}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 zreg", {16'd0, zreg_q}, 32'd0);
        rst_n = 1'b1;
        tick();
        chk("R1 after release", {31'd0, zc_pulse}, 32'd0);

        // R12 software write
        wr_zreg(16'h0100);
        chk("R12 sw write", {16'd0, zreg_q}, 32'h0100);

        // table walk
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][38], VEC[i][37], VEC[i][36], VEC[i][35], VEC[i][34:19]);
            tick();
            chk($sformatf("R2-table vec %0d pulse", i), {31'd0, zc_pulse}, {31'd0, VEC[i][18]});
            if (VEC[i][18])
                chk($sformatf("R6/R7 table vec %0d src", i), {31'd0, zc_src_hw}, {31'd0, VEC[i][17]});
            chk($sformatf("R10 table vec %0d flag", i), {31'd0, irq_flag}, {31'd0, VEC[i][16]});
            chk($sformatf("R8 table vec %0d zreg", i), {16'd0, zreg_q}, {16'd0, VEC[i][15:0]});
        end

        // R9 stale compare, strictly behind
        wr_zreg(16'h0050);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 16'h0058); tick();
        drive(1'b0, 1'b1, 1'b0, 1'b0, 16'h0060); tick();
        chk("R9 stale pulse", {31'd0, zc_pulse}, 32'd1);
        chk("R9 stale src", {31'd0, zc_src_hw}, 32'd0);
        chk("R9 stale zreg", {16'd0, zreg_q}, 32'h0060);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h0050); tick();
        chk("R9 spent after stale", {31'd0, zc_pulse}, 32'd0);

        // R9 equal boundary
        wr_zreg(16'h0070);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 16'h0068); tick();
        drive(1'b0, 1'b1, 1'b0, 1'b0, 16'h0070); tick();
        chk("R9 equal pulse", {31'd0, zc_pulse}, 32'd1);
        chk("R9 equal zreg", {16'd0, zreg_q}, 32'h0070);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h0071);

        // R10 mask
        cfg_irq_mask = 1'b0; #1;
        chk("R10 masked irq", {31'd0, irq}, 32'd0);
        cfg_irq_mask = 1'b1; #1;
        chk("R10 unmasked irq", {31'd0, irq}, 32'd1);

        // R11 clear alone, then clear against an event
        irq_clr = 1'b1; tick(); irq_clr = 1'b0;
        chk("R11 clear", {31'd0, irq_flag}, 32'd0);
        wr_zreg(16'h0030);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 16'h0020); tick();
        drive(1'b0, 1'b1, 1'b0, 1'b0, 16'h0040); irq_clr = 1'b1; tick(); irq_clr = 1'b0;
        chk("R11 event beats clear", {31'd0, irq_flag}, 32'd1);

        // R2 c and d together: c wins, no arming
        cfg_sim_en = 1'b0;
        drive(1'b1, 1'b1, 1'b1, 1'b1, 16'h0001); tick();
        drive(1'b0, 1'b0, 1'b1, 1'b1, 16'h0002); tick();
        drive(1'b0, 1'b0, 1'b1, 1'b1, 16'h0003); tick();
        chk("R2 c beats d", {31'd0, zc_pulse}, 32'd0);

        // R5 polarity: falling, inverted, single sample
        cfg_edge_rise = 1'b0; cfg_cmp_inv = 1'b1; cfg_filt_len = 3'd0;
        drive(1'b0, 1'b1, 1'b1, 1'b0, 16'h0010); tick();
        drive(1'b0, 1'b0, 1'b1, 1'b0, 16'h0011); tick();
        chk("R5 non-qualifying", {31'd0, zc_pulse}, 32'd0);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 16'h0012); tick();
        chk("R5 qualifying pulse", {31'd0, zc_pulse}, 32'd1);
        chk("R5 src hw", {31'd0, zc_src_hw}, 32'd1);
        chk("R6 capture", {16'd0, zreg_q}, 32'h0012);

        // R12 capture beats software write
        drive(1'b1, 1'b0, 1'b1, 1'b0, 16'h0200); tick();
        drive(1'b0, 1'b1, 1'b1, 1'b0, 16'h0201); tick();
        drive(1'b0, 1'b0, 1'b1, 1'b1, 16'h0222);
        zreg_wr = 1'b1; zreg_wdata = 16'h0DEF; tick(); zreg_wr = 1'b0;
        chk("R12 capture wins", {16'd0, zreg_q}, 32'h0222);

        // R6/R7 both sources disabled
        cfg_hw_en = 1'b0;
        drive(1'b1, 1'b0, 1'b1, 1'b0, 16'h0220); tick();
        drive(1'b0, 1'b1, 1'b1, 1'b0, 16'h0221); tick();
        drive(1'b0, 1'b0, 1'b1, 1'b1, 16'h0222); tick();
        chk("R6 R7 disabled", {31'd0, zc_pulse}, 32'd0);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 16'h0223); tick();
        chk("R6 disabled no capture", {16'd0, zreg_q}, 32'h0222);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule